// File: doc/BRIEF.md
# Two-Byte Lane Comma Realigner

This block follows a deserializer and 8b10b decoder that hands over two decoded bytes per clock on a 16-bit bus. Each byte comes with its own control-character flag. The byte that came first on the line sits in the low half of the bus. The block searches both byte lanes for the K28.5 comma on every cycle. From the lane it finds the comma in, it works out whether the receive word boundary matches the transmit boundary, which places the comma in the high lane.

When the comma shows up in the high lane, words pass straight through. When it shows up in the low lane, the receive boundary is one byte off. Each output word is then rebuilt from the current low byte and the high byte of the previous cycle. The control flags follow their bytes under the same rule.

The lane decision is kept between commas. A lock output rises with the first comma after reset. A sticky error flag records any cycle that carries commas in both lanes. Both the pass-through path and the realign path leave through one output register, so the latency does not change when the mode flips.

Top module: `comma_realigner`

## Requirements
- R1: After synchronous reset, and until a new word has been clocked through, `al_data`, `al_ctl`, `shift_mode`, `locked` and `dual_comma_err` are all 0 (pass-through mode).
- R2: A byte lane holds a comma only when its data equals `COMMA_CODE` (default 0xBC) and its control flag is 1. Lane 0 is `rx_data[7:0]`/`rx_ctl[0]` (earlier byte) and lane 1 is `rx_data[15:8]`/`rx_ctl[1]`. A byte of 0xBC with its flag at 0 changes nothing.
- R3: A cycle with a comma only in lane 1 selects pass-through for that word and later words. One cycle later, `al_data`/`al_ctl` equal that cycle's `rx_data`/`rx_ctl` and `shift_mode` is 0.
- R4: A cycle with a comma only in lane 0 selects shift mode for that word and later words. One cycle later, `al_data[15:8]` holds that cycle's `rx_data[7:0]`, `al_data[7:0]` holds the previous cycle's `rx_data[15:8]`, the `al_ctl` bits follow the same rule, and `shift_mode` is 1.
- R5: On cycles with no comma in either lane, the mode stays as it was.
- R6: A cycle with commas in both lanes keeps the current mode and sets `dual_comma_err`. The flag stays at 1 until reset.
- R7: `locked` rises one cycle after the first cycle that holds any comma and stays at 1 until reset.
- R8: The previous-high-byte register loads on every cycle in either mode. The output latency is exactly one cycle in both modes, including the first shifted word after a switch from pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 16 | Decoded byte pair, earlier byte in the low half |
| rx_ctl | input | 2 | Control-character flag for each byte |
| al_data | output | 16 | Realigned byte pair |
| al_ctl | output | 2 | Control flags of the realigned byte pair |
| shift_mode | output | 1 | 1 while words are rebuilt across cycles |
| locked | output | 1 | A comma has been seen since reset |
| dual_comma_err | output | 1 | Sticky: commas seen in both lanes at once |

## Verification
The bench builds the block with its default byte width of 8 and comma code 0xBC. This lets the bench inject real K28.5 symbols, and lets it send uncontrolled 0xBC bytes that must be rejected. A bench model tracks the mode, the previous high byte, lock and the error flag. The random streams space commas an even number of bytes apart and switch lanes between phases, which exercises the first shifted word after a mode switch. Directed cases cover reset, dual commas and flagless 0xBC bytes.

// File: rtl/realign_pkg.sv
package realign_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = BYTE_W * LANES;

    typedef struct packed {
        logic              ctl;
        logic [BYTE_W-1:0] dat;
    } sym_t;

    typedef struct packed {
        sym_t hi;
        sym_t lo;
    } word_t;

    typedef enum logic {
        MODE_PASS  = 1'b0,
        MODE_SHIFT = 1'b1
    } align_mode_e;

    function automatic logic sym_is_comma(sym_t s, logic [BYTE_W-1:0] code);
        return s.ctl && (s.dat == code);
    endfunction

    function automatic word_t pack_word(logic [WORD_W-1:0] d, logic [LANES-1:0] c);
        word_t w;
        w.lo.dat = d[BYTE_W-1:0];
        w.lo.ctl = c[0];
        w.hi.dat = d[WORD_W-1:BYTE_W];
        w.hi.ctl = c[1];
        return w;
    endfunction

    function automatic align_mode_e pick_mode(logic hit_lo, logic hit_hi, align_mode_e held);
        if (hit_lo && !hit_hi)
            return MODE_SHIFT;
        else if (hit_hi && !hit_lo)
            return MODE_PASS;
        else
            return held;
    endfunction

endpackage

// File: rtl/comma_lane_detect.sv
module comma_lane_detect
    import realign_pkg::*;
#(
    parameter logic [BYTE_W-1:0] COMMA_CODE = 8'hBC
) (
    input  sym_t sym,
    output logic hit
);
    assign hit = sym_is_comma(sym, COMMA_CODE);
endmodule

// File: rtl/align_mode_ctrl.sv
module align_mode_ctrl
    import realign_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hit_lo,
    input  logic        hit_hi,
    output align_mode_e sel_mode,
    output align_mode_e mode_q,
    output logic        locked_q,
    output logic        dual_err_q
);
    assign sel_mode = pick_mode(hit_lo, hit_hi, mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= MODE_PASS;
            locked_q   <= 1'b0;
            dual_err_q <= 1'b0;
        end else begin
            mode_q <= sel_mode;
            if (hit_lo || hit_hi)
                locked_q <= 1'b1;
            if (hit_lo && hit_hi)
                dual_err_q <= 1'b1;
        end
    end

    AST_NO_COMMA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!hit_lo && !hit_hi) |=> $stable(mode_q)); // R5
    AST_DUAL_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        (hit_lo && hit_hi) |=> ($stable(mode_q) && dual_err_q)); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        dual_err_q |=> dual_err_q); // R6
    AST_LOW_COMMA_SHIFTS: assert property (@(posedge clk) disable iff (rst)
        (hit_lo && !hit_hi) |=> (mode_q == MODE_SHIFT)); // R4
    AST_HIGH_COMMA_PASSES: assert property (@(posedge clk) disable iff (rst)
        (hit_hi && !hit_lo) |=> (mode_q == MODE_PASS)); // R3
    AST_LOCK_ON_COMMA: assert property (@(posedge clk) disable iff (rst)
        (hit_lo || hit_hi) |=> locked_q); // R7
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> locked_q); // R7
endmodule

// File: rtl/lane_merge.sv
module lane_merge
    import realign_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  word_t       cur,
    input  align_mode_e sel,
    output word_t       out_q
);
    sym_t  prev_hi_q;
    word_t merged;

    always_comb begin
        if (sel == MODE_SHIFT) begin
            merged.hi = cur.lo;
            merged.lo = prev_hi_q;
        end else begin
            merged = cur;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_hi_q <= '0;
            out_q     <= '0;
        end else begin
            prev_hi_q <= cur.hi;
            out_q     <= merged;
        end
    end

    AST_PASS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (sel == MODE_PASS) |=> (out_q == $past(cur))); // R3
    AST_SHIFT_HIGH_FROM_LOW: assert property (@(posedge clk) disable iff (rst)
        (sel == MODE_SHIFT) |=> (out_q.hi == $past(cur.lo))); // R4
    AST_PREV_ALWAYS_LOADS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (prev_hi_q == $past(cur.hi))); // R8
endmodule

// File: rtl/comma_realigner.sv
module comma_realigner
    import realign_pkg::*;
#(
    parameter logic [BYTE_W-1:0] COMMA_CODE = 8'hBC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] rx_data,
    input  logic [LANES-1:0]  rx_ctl,
    output logic [WORD_W-1:0] al_data,
    output logic [LANES-1:0]  al_ctl,
    output logic              shift_mode,
    output logic              locked,
    output logic              dual_comma_err
);
    word_t       cur_word;
    word_t       out_word;
    sym_t        lane_sym [LANES];
    logic [LANES-1:0] lane_hit;
    align_mode_e sel_mode;
    align_mode_e mode_q;

    assign cur_word    = pack_word(rx_data, rx_ctl);
    assign lane_sym[0] = cur_word.lo;
    assign lane_sym[1] = cur_word.hi;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        comma_lane_detect #(.COMMA_CODE(COMMA_CODE)) u_det (
            .sym (lane_sym[g]),
            .hit (lane_hit[g])
        );
    end

    align_mode_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .hit_lo     (lane_hit[0]),
        .hit_hi     (lane_hit[1]),
        .sel_mode   (sel_mode),
        .mode_q     (mode_q),
        .locked_q   (locked),
        .dual_err_q (dual_comma_err)
    );

    lane_merge u_merge (
        .clk   (clk),
        .rst   (rst),
        .cur   (cur_word),
        .sel   (sel_mode),
        .out_q (out_word)
    );

    assign al_data    = {out_word.hi.dat, out_word.lo.dat};
    assign al_ctl     = {out_word.hi.ctl, out_word.lo.ctl};
    assign shift_mode = (mode_q == MODE_SHIFT);

    AST_MODE_MATCHES_WORD: assert property (@(posedge clk) disable iff (rst)
        (lane_hit == 2'b01) |=> (shift_mode && al_data[15:8] == COMMA_CODE && al_ctl[1])); // R4
    AST_COMMA_LANDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (lane_hit == 2'b10) |=> (!shift_mode && al_data[15:8] == COMMA_CODE && al_ctl[1])); // R3
    AST_LOCK_FIRST: assert property (@(posedge clk) disable iff (rst)
        (|lane_hit) |=> locked); // R7
endmodule

// File: tb/comma_realigner_test.sv
module comma_realigner_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] rx_data;
    logic [1:0]  rx_ctl;
    logic [15:0] al_data;
    logic [1:0]  al_ctl;
    logic        shift_mode, locked, dual_comma_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    bit       m_shift, m_lock, m_err;
    bit [7:0] p_hi;
    bit       p_ctl;

    always #4 clk = ~clk; // 125 MHz

    comma_realigner uut (
        .clk(clk), .rst(rst), .rx_data(rx_data), .rx_ctl(rx_ctl),
        .al_data(al_data), .al_ctl(al_ctl), .shift_mode(shift_mode),
        .locked(locked), .dual_comma_err(dual_comma_err)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic bit is_k(bit [7:0] d, bit c);
        return c && d == 8'hBC;
    endfunction

    task automatic step(bit [15:0] d, bit [1:0] c, string tag);
        bit hl, hh, sel;
        bit [15:0] ed;
        bit [1:0]  ec;
        hl = is_k(d[7:0], c[0]);
        hh = is_k(d[15:8], c[1]);
        sel = (hl ^ hh) ? hl : m_shift;
        ed = sel ? {d[7:0], p_hi} : d;
        ec = sel ? {c[0], p_ctl} : c;
        m_shift = sel;
        p_hi = d[15:8];
        p_ctl = c[1];
        if (hl || hh) m_lock = 1'b1;
        if (hl && hh) m_err = 1'b1;
        rx_data = d;
        rx_ctl = c;
        @(posedge clk);
        @(negedge clk);
        check(sel ? "R4 data" : "R3 data", al_data, ed);
        check(sel ? "R4 ctl" : "R3 ctl", al_ctl, ec);
        check((hl || hh) ? "R3/R4 mode" : "R5 mode", shift_mode, sel);
        check("R7 lock", locked, m_lock);
        check("R6 err", dual_comma_err, m_err);
        if (tag.len() > 0) check(tag, al_data, ed);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rx_data = 16'h0;
        rx_ctl = 2'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_shift = 0; m_lock = 0; m_err = 0; p_hi = 0; p_ctl = 0;
        check("R1 data", al_data, 16'h0);
        check("R1 ctl", al_ctl, 2'b0);
        check("R1 mode", shift_mode, 1'b0);
        check("R1 lock", locked, 1'b0);
        check("R1 err", dual_comma_err, 1'b0);
    endtask

    function automatic bit [8:0] rand_sym();
        bit [7:0] d;
        bit c;
        d = 8'($urandom);
        c = ($urandom % 8) == 0;
        if (c && d == 8'hBC) c = 1'b0;
        return {c, d};
    endfunction

    task automatic random_phase(int cycles, bit lane_lo);
        for (int i = 0; i < cycles; i++) begin
            bit [8:0] a, b;
            a = rand_sym();
            b = rand_sym();
            if (i % 6 == 2) begin
                if (lane_lo) a = {1'b1, 8'hBC};
                else         b = {1'b1, 8'hBC};
            end
            step({b[7:0], a[7:0]}, {b[8], a[8]}, "");
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        do_reset();
        // R2: uncontrolled 0xBC in either lane is no comma
        step(16'hBCBC, 2'b00, "R2 plain BC");
        check("R2 no lock", locked, 1'b0);
        check("R2 mode", shift_mode, 1'b0);
        // R4 / R8: switch to shift, first shifted word uses previous high byte
        step(16'h5A11, 2'b00, "R8 pre");
        step(16'h22BC, 2'b01, "R8 first shifted");
        check("R8 low byte from prev", al_data[7:0], 8'h5A);
        step(16'h3344, 2'b00, "R5 held shift");
        random_phase(300, 1'b1);
        // R3: back to pass-through
        step(16'hBC77, 2'b10, "R3 realign to pass");
        random_phase(300, 1'b0);
        // R6: dual comma keeps mode and sets sticky error
        step(16'hBCBC, 2'b11, "R6 dual");
        check("R6 err set", dual_comma_err, 1'b1);
        random_phase(50, 1'b1);
        check("R6 err sticky", dual_comma_err, 1'b1);
        step(16'hBCBC, 2'b11, "R6 dual in shift");
        random_phase(50, 1'b0);
        do_reset();
        step(16'h1234, 2'b10, "R1 after reset");
        random_phase(100, 1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule